// File: doc/BRIEF.md
# Floating-Point Exception Status Unit

This block keeps the IEEE-754 exception state of a floating-point pipeline and decides whether a finished operation raises a trap. Each completed operation is offered on a valid/ready port together with a 5-bit exception vector. The unit holds three fields that software can write: a per-exception trap-enable mask, a current-exception field and an accrued-exception field. When an operation raises an exception whose trap is enabled, the unit asserts a trap request and reports a trap-type code. The request stays up until the trap controller acknowledges it.

A status port gives software the whole state as one word. A write replaces the mask and both flag fields. The trap-type code and a queue-not-empty bit are read-only and show in the same word. Back-pressure rule: the unit holds `op_ready` low while a trap request is pending. An operation is taken only in a cycle where `op_valid` and `op_ready` are both high. The producer must keep `op_valid` and `op_exc` stable until that happens.

Top module: `fpx_status_unit`

## Requirements
- R1: After reset the mask, the current and accrued fields and the trap-type code read 0. `trap_req` is 0 and `op_ready` is 1.
- R2: Every 5-bit field uses this bit order: bit 4 invalid, bit 3 overflow, bit 2 underflow, bit 1 divide-by-zero, bit 0 inexact. The cycle after an operation is taken, the current field equals that operation's vector after R3 is applied. Bits of exceptions that did not occur are cleared.
- R3: If a vector has both bit 4 (invalid) and bit 1 (divide-by-zero) set, it is treated as invalid alone. Bit 1 is dropped before the current field, the accrued field and the trap decision use the vector.
- R4: If (vector AND mask) is nonzero for a taken operation, the next cycle shows `trap_req` = 1 and trap-type code 1. The accrued field is left unchanged.
- R5: If (vector AND mask) is zero for a taken operation, the accrued field becomes its old value OR the vector, and the trap-type code becomes 0.
- R6: `trap_req` stays high until a cycle with `trap_ack` high, and then drops on the next edge. While `trap_req` is high, `op_ready` is low and an offered operation changes no field.
- R7: A status write loads the accrued field from bits [4:0], the current field from bits [9:5] and the mask from bits [14:10]. The read-only trap-type code (bits [17:15]) and queue bit (bit 18) are not changed by a write. All other bits read 0.
- R8: If a status write and a taken operation fall in the same cycle, the written values win for the mask and both flag fields.
- R9: Status bit 18 shows `fq_not_empty` in the same cycle: 1 when the deferred-trap queue holds entries, 0 when it is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | A finished operation is offered |
| op_ready | output | 1 | The unit can take an operation (low while a trap is pending) |
| op_exc | input | 5 | Exception vector of the offered operation |
| trap_req | output | 1 | Trap request, held until acknowledged |
| trap_type | output | TT_W | Trap-type code (1 = IEEE exception, 0 = none) |
| trap_ack | input | 1 | Trap controller takes the pending request |
| reg_wr | input | 1 | Status write strobe |
| reg_wdata | input | REG_W | Status write data |
| reg_rdata | output | REG_W | Status read data |
| fq_not_empty | input | 1 | Deferred-trap queue holds entries |

## Verification
The bench sweeps all 1024 pairs of mask and exception vector. Before each operation it preloads a non-trivial accrued value and an all-ones current value. This exposes a unit that only sets current bits and never clears them. It also exposes one that accrues flags on a trapping operation, or one that lets divide-by-zero through beside invalid. Further tests offer an operation while a trap is pending, which catches a unit that ignores back-pressure or drops the request before the acknowledge. Others collide a status write with an operation, which shows when the operation overrides software. A final test writes ones into the read-only bits, which shows when a write reaches the trap code or the queue bit.

// File: rtl/fpx_pkg.sv
package fpx_pkg;
  localparam int EXC_W = 5;
  localparam int EXC_NV = 4;
  localparam int EXC_OF = 3;
  localparam int EXC_UF = 2;
  localparam int EXC_DZ = 1;
  localparam int EXC_NX = 0;

  localparam int AEXC_LSB = 0;
  localparam int CEXC_LSB = AEXC_LSB + EXC_W;
  localparam int MASK_LSB = CEXC_LSB + EXC_W;
  localparam int TT_LSB   = MASK_LSB + EXC_W;

  localparam int TT_CODE_NONE = 0;
  localparam int TT_CODE_IEEE = 1;

  typedef logic [EXC_W-1:0] exc_vec_t;
endpackage

// File: rtl/fpx_exc_filter.sv
module fpx_exc_filter
  import fpx_pkg::*;
(
  input  exc_vec_t raw_exc,
  input  exc_vec_t trap_mask,
  output exc_vec_t norm_exc,
  output logic     trap_hit
);
  // Zero over zero is reported as invalid only: drop divide-by-zero beside it.
  always_comb begin
    norm_exc = raw_exc;
    if (raw_exc[EXC_NV] && raw_exc[EXC_DZ]) begin
      norm_exc[EXC_DZ] = 1'b0;
    end
  end

  assign trap_hit = |(norm_exc & trap_mask);
endmodule

// File: rtl/fpx_flag_regs.sv
module fpx_flag_regs
  import fpx_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     fire,
  input  exc_vec_t norm_exc,
  input  logic     trap_hit,
  input  logic     sw_wr,
  input  exc_vec_t sw_mask,
  input  exc_vec_t sw_cexc,
  input  exc_vec_t sw_aexc,
  output exc_vec_t mask_q,
  output exc_vec_t cexc_q,
  output exc_vec_t aexc_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= '0;
      cexc_q <= '0;
      aexc_q <= '0;
    end else if (sw_wr) begin
      mask_q <= sw_mask;
      cexc_q <= sw_cexc;
      aexc_q <= sw_aexc;
    end else if (fire) begin
      cexc_q <= norm_exc;
      if (!trap_hit) begin
        aexc_q <= aexc_q | norm_exc;
      end
    end
  end
endmodule

// File: rtl/fpx_trap_ctrl.sv
module fpx_trap_ctrl
  import fpx_pkg::*;
#(
  parameter int TT_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fire,
  input  logic            trap_hit,
  input  logic            trap_ack,
  output logic            trap_req,
  output logic [TT_W-1:0] trap_type
);
  localparam logic [TT_W-1:0] TT_IEEE = TT_W'(TT_CODE_IEEE);
  localparam logic [TT_W-1:0] TT_NONE = TT_W'(TT_CODE_NONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trap_req  <= 1'b0;
      trap_type <= TT_NONE;
    end else if (fire) begin
      trap_req  <= trap_hit;
      trap_type <= trap_hit ? TT_IEEE : TT_NONE;
    end else if (trap_ack) begin
      trap_req <= 1'b0;
    end
  end
endmodule

// File: rtl/fpx_status_unit.sv
module fpx_status_unit
  import fpx_pkg::*;
#(
  parameter int REG_W = 32,
  parameter int TT_W  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_valid,
  output logic             op_ready,
  input  logic [4:0]       op_exc,
  output logic             trap_req,
  output logic [TT_W-1:0]  trap_type,
  input  logic             trap_ack,
  input  logic             reg_wr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic             fq_not_empty
);
  localparam int QNE_BIT = TT_LSB + TT_W;

  exc_vec_t norm_exc, mask_q, cexc_q, aexc_q;
  logic     trap_hit, fire;

  assign op_ready = !trap_req;
  assign fire     = op_valid && op_ready;

  fpx_exc_filter u_filter (
    .raw_exc  (op_exc),
    .trap_mask(mask_q),
    .norm_exc (norm_exc),
    .trap_hit (trap_hit)
  );

  fpx_flag_regs u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .fire    (fire),
    .norm_exc(norm_exc),
    .trap_hit(trap_hit),
    .sw_wr   (reg_wr),
    .sw_mask (reg_wdata[MASK_LSB +: EXC_W]),
    .sw_cexc (reg_wdata[CEXC_LSB +: EXC_W]),
    .sw_aexc (reg_wdata[AEXC_LSB +: EXC_W]),
    .mask_q  (mask_q),
    .cexc_q  (cexc_q),
    .aexc_q  (aexc_q)
  );

  fpx_trap_ctrl #(.TT_W(TT_W)) u_trap (
    .clk      (clk),
    .rst_n    (rst_n),
    .fire     (fire),
    .trap_hit (trap_hit),
    .trap_ack (trap_ack),
    .trap_req (trap_req),
    .trap_type(trap_type)
  );

  always_comb begin
    reg_rdata = '0;
    reg_rdata[AEXC_LSB +: EXC_W] = aexc_q;
    reg_rdata[CEXC_LSB +: EXC_W] = cexc_q;
    reg_rdata[MASK_LSB +: EXC_W] = mask_q;
    reg_rdata[TT_LSB +: TT_W]    = trap_type;
    reg_rdata[QNE_BIT]           = fq_not_empty;
  end
endmodule

// File: rtl/fpx_status_chk.sv
module fpx_status_chk #(
  parameter int REG_W = 32,
  parameter int TT_W  = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             op_valid,
  input logic             op_ready,
  input logic [4:0]       op_exc,
  input logic             trap_req,
  input logic [TT_W-1:0]  trap_type,
  input logic             trap_ack,
  input logic             reg_wr,
  input logic [REG_W-1:0] reg_rdata
);
  logic [4:0] aexc_v, cexc_v;
  assign aexc_v = reg_rdata[4:0];
  assign cexc_v = reg_rdata[9:5];

  AST_TRAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req && !trap_ack |=> trap_req); // R6
  AST_ACK_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req && trap_ack |=> !trap_req); // R6
  AST_BACKPRESSURE: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> !op_ready); // R6
  AST_TRAP_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trap_req) |-> trap_type == TT_W'(1)); // R4
  AST_ZDIV_AS_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op_ready && !reg_wr && op_exc[4] |=> !cexc_v[1]); // R3
  AST_CEXC_FOLLOWS_OP: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op_ready && !reg_wr && !op_exc[4] |=> cexc_v == $past(op_exc)); // R2
  AST_ACCRUE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_wr |=> (aexc_v & $past(aexc_v)) == $past(aexc_v)); // R5
  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !op_ready && !reg_wr |=> $stable(cexc_v)); // R6
endmodule

bind fpx_status_unit fpx_status_chk #(.REG_W(REG_W), .TT_W(TT_W)) i_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .op_valid (op_valid),
  .op_ready (op_ready),
  .op_exc   (op_exc),
  .trap_req (trap_req),
  .trap_type(trap_type),
  .trap_ack (trap_ack),
  .reg_wr   (reg_wr),
  .reg_rdata(reg_rdata)
);

// File: tb/test_fpx_status_unit.sv
`timescale 1ns/1ps
module test_fpx_status_unit;
  localparam int REG_W = 32;
  localparam int TT_W  = 3;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             op_valid = 1'b0;
  logic             op_ready;
  logic [4:0]       op_exc = '0;
  logic             trap_req;
  logic [TT_W-1:0]  trap_type;
  logic             trap_ack = 1'b0;
  logic             reg_wr = 1'b0;
  logic [REG_W-1:0] reg_wdata = '0;
  logic [REG_W-1:0] reg_rdata;
  logic             fq_not_empty = 1'b0;

  int n_tests = 0;
  int n_fail  = 0;

  always #2.5 clk = ~clk;

  fpx_status_unit #(.REG_W(REG_W), .TT_W(TT_W)) i_fpx_status_unit (.*);

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] pack(input logic [4:0] m, input logic [4:0] c,
                                       input logic [4:0] a);
    return {17'd0, m, c, a};
  endfunction

  task automatic sw_write(input logic [31:0] w);
    @(negedge clk);
    reg_wr = 1'b1;
    reg_wdata = w;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic op_issue(input logic [4:0] e);
    op_valid = 1'b1;
    op_exc = e;
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  task automatic ack_trap();
    trap_ack = 1'b1;
    @(negedge clk);
    trap_ack = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "status word", reg_rdata, 32'h0);
    chk("R1", "trap_req", {31'd0, trap_req}, 32'd0);
    chk("R1", "op_ready", {31'd0, op_ready}, 32'd1);

    // R2 R3 R4 R5 exhaustive mask x vector sweep
    for (int m = 0; m < 32; m++) begin
      for (int e = 0; e < 32; e++) begin
        logic [4:0] mk, ex, nrm, a0, ea;
        logic hit;
        mk = 5'(m);
        ex = 5'(e);
        a0 = mk ^ 5'h0A;
        nrm = ex;
        if (ex[4] && ex[1]) nrm[1] = 1'b0;
        hit = |(nrm & mk);
        ea = hit ? a0 : (a0 | nrm);
        sw_write(pack(mk, 5'h1F, a0));
        op_issue(ex);
        chk((ex[4] && ex[1]) ? "R3" : "R2", "current field", {27'd0, reg_rdata[9:5]}, {27'd0, nrm});
        chk(hit ? "R4" : "R5", "accrued field", {27'd0, reg_rdata[4:0]}, {27'd0, ea});
        chk(hit ? "R4" : "R5", "trap type", {29'd0, trap_type}, hit ? 32'd1 : 32'd0);
        chk("R4", "trap_req", {31'd0, trap_req}, {31'd0, hit});
        if (hit) ack_trap();
      end
    end

    // R6 back-pressure while trap pending
    sw_write(pack(5'h1F, 5'h00, 5'h00));
    op_issue(5'h01);
    chk("R6", "trap raised", {31'd0, trap_req}, 32'd1);
    op_valid = 1'b1;
    op_exc = 5'h08;
    @(negedge clk);
    @(negedge clk);
    chk("R6", "op_ready while pending", {31'd0, op_ready}, 32'd0);
    chk("R6", "request held", {31'd0, trap_req}, 32'd1);
    chk("R6", "current unchanged", {27'd0, reg_rdata[9:5]}, 32'h01);
    op_valid = 1'b0;
    ack_trap();
    chk("R6", "request cleared", {31'd0, trap_req}, 32'd0);
    chk("R6", "ready restored", {31'd0, op_ready}, 32'd1);

    // R8 write beats same-cycle operation
    sw_write(pack(5'h00, 5'h00, 5'h00));
    reg_wr = 1'b1;
    reg_wdata = pack(5'h02, 5'h03, 5'h04);
    op_issue(5'h10);
    reg_wr = 1'b0;
    chk("R8", "current from write", {27'd0, reg_rdata[9:5]}, 32'h03);
    chk("R8", "accrued from write", {27'd0, reg_rdata[4:0]}, 32'h04);
    chk("R8", "mask from write", {27'd0, reg_rdata[14:10]}, 32'h02);

    // R7 read-only fields ignore writes
    sw_write(32'hFFFF_FFFF);
    chk("R7", "status after all-ones write", reg_rdata, 32'h0000_7FFF);

    // R9 queue bit mirrors input
    fq_not_empty = 1'b1;
    #1;
    chk("R9", "queue bit set", {31'd0, reg_rdata[18]}, 32'd1);
    fq_not_empty = 1'b0;
    #1;
    chk("R9", "queue bit clear", {31'd0, reg_rdata[18]}, 32'd0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule